// File: doc/BRIEF.md
# Coherency Port Transaction ID Mapper

This block sits in front of a coherent slave port that accepts only 3-bit AXI transaction IDs. Many interconnect masters send requests with 12-bit IDs, and the block translates each of those IDs into one of the narrow slots. Slots 0 and 1 belong to the processor cores and are never handed out. Slots 2 to 6 can each be bound by configuration to one specific input ID (fixed use) or left in a shared pool. Slot 7 can only be pooled. A pooled slot is lent to the first input ID that arrives while it is free. It stays lent while that ID has requests outstanding, and it returns to the pool when the matching completions have come back.

Along with the ID, the block rewrites two other request fields. The top two address bits pick one of four 1 GiB pages, so the block's 1 GiB window can be placed anywhere in the 4 GiB space. The 5-bit user sideband is replaced with a configured value, except for the fabric bridge master, whose own user value passes through. Fixed slots carry their own page and user value. All pooled slots on a channel share one page and one user value. The read and write channels have separate tables and separate pool settings, and they share a single configuration port.

Top module: `coh_id_mapper`

## Requirements
- R1: After synchronous reset, on both channels slot 2 is fixed to input ID 0x004 with page 0 and user 0. Slots 3 to 7 are pooled and free, the shared page and user are 0, both output valids are low and `cfg_err` is low.
- R2: A request whose ID equals the bound ID of a fixed slot is accepted at once and translated to that slot number, with that slot's page and user. A fixed binding takes precedence over any pooled binding of the same ID, and among several fixed slots the lowest number wins.
- R3: A request whose ID holds no binding takes the lowest-numbered free pooled slot. Output IDs 0 and 1 are never produced.
- R4: A request whose ID already holds a pooled slot reuses that slot and raises its outstanding count by one.
- R5: A completion (`*_done_valid` with slot `*_done_id`) lowers that pooled slot's count by one, and the slot becomes free at zero. A completion that names a fixed slot or a slot with a zero count has no effect. An acceptance and a completion on the same slot in the same cycle leave the count unchanged.
- R6: `*_req_ready` is low when the ID has no fixed slot and either no pooled slot is free or the ID's pooled slot count is at its maximum of 2^CNT_W−1 (7 by default). A request that is not accepted produces no output.
- R7: The translated address is {page[1:0], addr[29:0]}: the low 30 bits are kept and the top 2 bits are the page.
- R8: When input ID bit 11 is 0 and bits 2:0 are 0, the input user value is passed unchanged. For every other ID the configured user value is sent out.
- R9: Read and write channels translate independently. A binding, a count or a configuration on one channel never changes the other.
- R10: A slot write (`cfg_dyn_opt`=0) that names slot 0 or 1, or that makes slot 7 fixed (`cfg_fixed`=1), changes nothing and drives `cfg_err` high for exactly the next cycle. `cfg_err` is low in every other cycle.
- R11: The outputs are registered. `*_out_valid` is high in the cycle after an acceptance and low otherwise, and the ID, address and user values shown are those of that acceptance.
- R12: `cfg_chan` selects the channel (0 read, 1 write). With `cfg_dyn_opt`=1, the write sets the channel's shared pooled page and user, and the slot and mode fields are ignored. With `cfg_dyn_opt`=0, the write sets the slot's mode (1 fixed), bound ID, page and user, and clears that slot's outstanding count. A slot write takes priority over a same-cycle request or completion on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request accepted this cycle when valid |
| rd_req_id | input | 12 | Read input transaction ID |
| rd_req_addr | input | 32 | Read request address |
| rd_req_user | input | 5 | Read request user sideband |
| rd_out_valid | output | 1 | Translated read request present |
| rd_out_id | output | 3 | Translated read ID |
| rd_out_addr | output | 32 | Paged read address |
| rd_out_user | output | 5 | Rewritten read user sideband |
| rd_done_valid | input | 1 | Read completion returned |
| rd_done_id | input | 3 | Slot of the returned read completion |
| wr_req_valid | input | 1 | Write request present |
| wr_req_ready | output | 1 | Write request accepted this cycle when valid |
| wr_req_id | input | 12 | Write input transaction ID |
| wr_req_addr | input | 32 | Write request address |
| wr_req_user | input | 5 | Write request user sideband |
| wr_out_valid | output | 1 | Translated write request present |
| wr_out_id | output | 3 | Translated write ID |
| wr_out_addr | output | 32 | Paged write address |
| wr_out_user | output | 5 | Rewritten write user sideband |
| wr_done_valid | input | 1 | Write completion returned |
| wr_done_id | input | 3 | Slot of the returned write completion |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Target channel: 0 read, 1 write |
| cfg_dyn_opt | input | 1 | 1: write shared pooled page/user; 0: write one slot |
| cfg_slot | input | 3 | Slot number for a slot write |
| cfg_fixed | input | 1 | Slot mode: 1 fixed, 0 pooled |
| cfg_in_id | input | 12 | Input ID bound to a fixed slot |
| cfg_page | input | 2 | Page value |
| cfg_user | input | 5 | User sideband value |
| cfg_err | output | 1 | Pulses for one cycle after a refused slot write |

## Verification
The hardest state to reach from the ports is one where a pooled slot's count is at its ceiling while other slots are busy, and a completion for that slot arrives in the same cycle as a new request. Directed sequences build that state: the same ID is issued seven times without completions, every other pooled slot on the write channel is filled, and then completions and requests are driven together. A precedence case binds an ID in the pool and afterwards makes another slot fixed to that same ID. A long randomised phase then mixes requests, completions and configuration writes on both channels, with a behavioural model checking ready and outputs on every clock.

// File: rtl/cpidm_pkg.sv
package cpidm_pkg;
  typedef enum logic {
    MODE_DYN = 1'b0,
    MODE_FIX = 1'b1
  } slot_mode_e;
endpackage

// File: rtl/cpidm_pick.sv
module cpidm_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cpidm_chan.sv
module cpidm_chan
  import cpidm_pkg::*;
#(
  parameter int IN_ID_W      = 12,
  parameter int OUT_ID_W     = 3,
  parameter int USER_W       = 5,
  parameter int PAGE_W       = 2,
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 3,
  parameter int FIRST_SLOT   = 2,
  parameter int RST_FIX_SLOT = 2,
  parameter int RST_FIX_ID   = 'h004
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IN_ID_W-1:0]  req_id,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [USER_W-1:0]   req_user,
  output logic                out_valid,
  output logic [OUT_ID_W-1:0] out_id,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [USER_W-1:0]   out_user,
  input  logic                done_valid,
  input  logic [OUT_ID_W-1:0] done_id,
  input  logic                cfg_we,
  input  logic                cfg_dyn_opt,
  input  logic [OUT_ID_W-1:0] cfg_slot,
  input  logic                cfg_fixed,
  input  logic [IN_ID_W-1:0]  cfg_in_id,
  input  logic [PAGE_W-1:0]   cfg_page,
  input  logic [USER_W-1:0]   cfg_user
);
  localparam int NSLOT = 1 << OUT_ID_W;
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  slot_mode_e         mode     [NSLOT];
  logic [IN_ID_W-1:0] fix_id   [NSLOT];
  logic [PAGE_W-1:0]  fix_page [NSLOT];
  logic [USER_W-1:0]  fix_user [NSLOT];
  logic [IN_ID_W-1:0] bnd_id   [NSLOT];
  logic [CNT_W-1:0]   cnt      [NSLOT];
  logic [PAGE_W-1:0]  dyn_page;
  logic [USER_W-1:0]  dyn_user;

  logic [NSLOT-1:0] fix_vec, bnd_vec, free_vec, inc_v, dec_v;
  logic fix_found, bnd_found, free_found;
  logic [OUT_ID_W-1:0] fix_idx, bnd_idx, free_idx, sel;
  logic sel_fix, ready_c, accept, pass_user;
  logic [PAGE_W-1:0] sel_page;
  logic [USER_W-1:0] sel_user;
  logic unused_hi;

  assign unused_hi = &{1'b0, req_addr[ADDR_W-1:OFS_W]};

  for (genvar s = 0; s < NSLOT; s++) begin : g_vec
    if (s < FIRST_SLOT) begin : g_rsvd
      assign fix_vec[s]  = 1'b0;
      assign bnd_vec[s]  = 1'b0;
      assign free_vec[s] = 1'b0;
      assign inc_v[s]    = 1'b0;
      assign dec_v[s]    = 1'b0;
    end else begin : g_live
      assign fix_vec[s]  = (mode[s] == MODE_FIX) && (fix_id[s] == req_id);
      assign bnd_vec[s]  = (mode[s] == MODE_DYN) && (cnt[s] != '0) && (bnd_id[s] == req_id);
      assign free_vec[s] = (mode[s] == MODE_DYN) && (cnt[s] == '0);
      assign inc_v[s]    = accept && !sel_fix && (sel == OUT_ID_W'(s));
      assign dec_v[s]    = done_valid && (done_id == OUT_ID_W'(s)) &&
                           (mode[s] == MODE_DYN) && (cnt[s] != '0);
    end
  end

  cpidm_pick #(.N(NSLOT)) u_pick_fix  (.vec(fix_vec),  .found(fix_found),  .idx(fix_idx));
  cpidm_pick #(.N(NSLOT)) u_pick_bnd  (.vec(bnd_vec),  .found(bnd_found),  .idx(bnd_idx));
  cpidm_pick #(.N(NSLOT)) u_pick_free (.vec(free_vec), .found(free_found), .idx(free_idx));

  // Fixed binding first, then an existing pooled binding, then a free slot.
  always_comb begin
    ready_c = 1'b0;
    sel     = '0;
    sel_fix = 1'b0;
    if (fix_found) begin
      ready_c = 1'b1;
      sel     = fix_idx;
      sel_fix = 1'b1;
    end else if (bnd_found) begin
      ready_c = (cnt[bnd_idx] != CNT_MAX);
      sel     = bnd_idx;
    end else if (free_found) begin
      ready_c = 1'b1;
      sel     = free_idx;
    end
  end

  assign req_ready = ready_c & ~rst;
  assign accept    = req_valid & req_ready;
  assign pass_user = (req_id[IN_ID_W-1] == 1'b0) && (req_id[2:0] == 3'b000);
  assign sel_page  = sel_fix ? fix_page[sel] : dyn_page;
  assign sel_user  = pass_user ? req_user : (sel_fix ? fix_user[sel] : dyn_user);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) begin
        mode[s]     <= (s == RST_FIX_SLOT) ? MODE_FIX : MODE_DYN;
        fix_id[s]   <= (s == RST_FIX_SLOT) ? IN_ID_W'(RST_FIX_ID) : '0;
        fix_page[s] <= '0;
        fix_user[s] <= '0;
        bnd_id[s]   <= '0;
        cnt[s]      <= '0;
      end
      dyn_page <= '0;
      dyn_user <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (cfg_we && !cfg_dyn_opt && (cfg_slot == OUT_ID_W'(s))) begin
          mode[s]     <= slot_mode_e'(cfg_fixed);
          fix_id[s]   <= cfg_in_id;
          fix_page[s] <= cfg_page;
          fix_user[s] <= cfg_user;
          cnt[s]      <= '0;
        end else begin
          if (inc_v[s]) bnd_id[s] <= req_id;
          cnt[s] <= cnt[s] + {{(CNT_W-1){1'b0}}, inc_v[s]} - {{(CNT_W-1){1'b0}}, dec_v[s]};
        end
      end
      if (cfg_we && cfg_dyn_opt) begin
        dyn_page <= cfg_page;
        dyn_user <= cfg_user;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      out_addr  <= '0;
      out_user  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_id   <= sel;
        out_addr <= {sel_page, req_addr[OFS_W-1:0]};
        out_user <= sel_user;
      end
    end
  end

  assert_out_id_legal_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_id >= OUT_ID_W'(FIRST_SLOT)));

  assert_out_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> out_valid);

  assert_no_spurious_out_R11: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !out_valid);

  assert_addr_offset_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (out_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));
endmodule

// File: rtl/coh_id_mapper.sv
module coh_id_mapper #(
  parameter int IN_ID_W    = 12,
  parameter int OUT_ID_W   = 3,
  parameter int USER_W     = 5,
  parameter int PAGE_W     = 2,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 3,
  parameter int FIRST_SLOT = 2,
  parameter int FIX_LAST   = 6,
  parameter int RST_FIX_ID = 'h004
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  input  logic [IN_ID_W-1:0]  rd_req_id,
  input  logic [ADDR_W-1:0]   rd_req_addr,
  input  logic [USER_W-1:0]   rd_req_user,
  output logic                rd_out_valid,
  output logic [OUT_ID_W-1:0] rd_out_id,
  output logic [ADDR_W-1:0]   rd_out_addr,
  output logic [USER_W-1:0]   rd_out_user,
  input  logic                rd_done_valid,
  input  logic [OUT_ID_W-1:0] rd_done_id,
  input  logic                wr_req_valid,
  output logic                wr_req_ready,
  input  logic [IN_ID_W-1:0]  wr_req_id,
  input  logic [ADDR_W-1:0]   wr_req_addr,
  input  logic [USER_W-1:0]   wr_req_user,
  output logic                wr_out_valid,
  output logic [OUT_ID_W-1:0] wr_out_id,
  output logic [ADDR_W-1:0]   wr_out_addr,
  output logic [USER_W-1:0]   wr_out_user,
  input  logic                wr_done_valid,
  input  logic [OUT_ID_W-1:0] wr_done_id,
  input  logic                cfg_we,
  input  logic                cfg_chan,
  input  logic                cfg_dyn_opt,
  input  logic [OUT_ID_W-1:0] cfg_slot,
  input  logic                cfg_fixed,
  input  logic [IN_ID_W-1:0]  cfg_in_id,
  input  logic [PAGE_W-1:0]   cfg_page,
  input  logic [USER_W-1:0]   cfg_user,
  output logic                cfg_err
);
  localparam int NCH = 2;

  logic [NCH-1:0]      q_v, q_r, o_v, d_v, ch_we;
  logic [IN_ID_W-1:0]  q_id   [NCH];
  logic [ADDR_W-1:0]   q_addr [NCH];
  logic [USER_W-1:0]   q_user [NCH];
  logic [OUT_ID_W-1:0] o_id   [NCH];
  logic [ADDR_W-1:0]   o_addr [NCH];
  logic [USER_W-1:0]   o_user [NCH];
  logic [OUT_ID_W-1:0] d_id   [NCH];
  logic cfg_bad;

  assign q_v       = {wr_req_valid, rd_req_valid};
  assign d_v       = {wr_done_valid, rd_done_valid};
  assign q_id[0]   = rd_req_id;
  assign q_id[1]   = wr_req_id;
  assign q_addr[0] = rd_req_addr;
  assign q_addr[1] = wr_req_addr;
  assign q_user[0] = rd_req_user;
  assign q_user[1] = wr_req_user;
  assign d_id[0]   = rd_done_id;
  assign d_id[1]   = wr_done_id;

  assign rd_req_ready = q_r[0];
  assign wr_req_ready = q_r[1];
  assign rd_out_valid = o_v[0];
  assign wr_out_valid = o_v[1];
  assign rd_out_id    = o_id[0];
  assign wr_out_id    = o_id[1];
  assign rd_out_addr  = o_addr[0];
  assign wr_out_addr  = o_addr[1];
  assign rd_out_user  = o_user[0];
  assign wr_out_user  = o_user[1];

  // Reserved slots and a fixed top slot are refused.
  assign cfg_bad = cfg_we && !cfg_dyn_opt &&
                   ((cfg_slot < OUT_ID_W'(FIRST_SLOT)) ||
                    (cfg_fixed && (cfg_slot > OUT_ID_W'(FIX_LAST))));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_we[c] = cfg_we && !cfg_bad && (cfg_chan == c[0]);

    cpidm_chan #(
      .IN_ID_W(IN_ID_W), .OUT_ID_W(OUT_ID_W), .USER_W(USER_W),
      .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .FIRST_SLOT(FIRST_SLOT), .RST_FIX_SLOT(FIRST_SLOT), .RST_FIX_ID(RST_FIX_ID)
    ) u_chan (
      .clk(clk), .rst(rst),
      .req_valid(q_v[c]), .req_ready(q_r[c]), .req_id(q_id[c]),
      .req_addr(q_addr[c]), .req_user(q_user[c]),
      .out_valid(o_v[c]), .out_id(o_id[c]), .out_addr(o_addr[c]), .out_user(o_user[c]),
      .done_valid(d_v[c]), .done_id(d_id[c]),
      .cfg_we(ch_we[c]), .cfg_dyn_opt(cfg_dyn_opt), .cfg_slot(cfg_slot),
      .cfg_fixed(cfg_fixed), .cfg_in_id(cfg_in_id), .cfg_page(cfg_page), .cfg_user(cfg_user)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_bad;
  end

  assert_err_on_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_dyn_opt && (cfg_slot < OUT_ID_W'(FIRST_SLOT))) |=> cfg_err);

  assert_err_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> !cfg_err);
endmodule

// File: tb/coh_id_mapper_tb_top.sv
`timescale 1ns/1ps
module coh_id_mapper_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]  b_qv, b_dv, t_qr, t_ov;
  logic [11:0] b_qid   [2];
  logic [31:0] b_qaddr [2];
  logic [4:0]  b_quser [2];
  logic [2:0]  b_did   [2];
  logic [2:0]  t_oid   [2];
  logic [31:0] t_oaddr [2];
  logic [4:0]  t_ouser [2];
  logic        c_we, c_chan, c_dyn, c_fx, t_err;
  logic [2:0]  c_slot;
  logic [11:0] c_id;
  logic [1:0]  c_pg;
  logic [4:0]  c_us;

  coh_id_mapper dut_i (
    .clk(clk), .rst(rst),
    .rd_req_valid(b_qv[0]), .rd_req_ready(t_qr[0]), .rd_req_id(b_qid[0]),
    .rd_req_addr(b_qaddr[0]), .rd_req_user(b_quser[0]),
    .rd_out_valid(t_ov[0]), .rd_out_id(t_oid[0]), .rd_out_addr(t_oaddr[0]), .rd_out_user(t_ouser[0]),
    .rd_done_valid(b_dv[0]), .rd_done_id(b_did[0]),
    .wr_req_valid(b_qv[1]), .wr_req_ready(t_qr[1]), .wr_req_id(b_qid[1]),
    .wr_req_addr(b_qaddr[1]), .wr_req_user(b_quser[1]),
    .wr_out_valid(t_ov[1]), .wr_out_id(t_oid[1]), .wr_out_addr(t_oaddr[1]), .wr_out_user(t_ouser[1]),
    .wr_done_valid(b_dv[1]), .wr_done_id(b_did[1]),
    .cfg_we(c_we), .cfg_chan(c_chan), .cfg_dyn_opt(c_dyn), .cfg_slot(c_slot),
    .cfg_fixed(c_fx), .cfg_in_id(c_id), .cfg_page(c_pg), .cfg_user(c_us),
    .cfg_err(t_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_fix [2][8];
  int m_fid [2][8];
  int m_fpg [2][8];
  int m_fus [2][8];
  int m_bid [2][8];
  int m_cnt [2][8];
  int m_dpg [2];
  int m_dus [2];
  int ev_sel [2];
  bit ev_fix [2];
  bit ev_acc [2];
  bit e_rdy  [2];
  bit e_ov   [2];
  int e_oid  [2];
  logic [31:0] e_oaddr [2];
  int e_ouser [2];
  bit e_err;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 8; s++) begin
        m_fix[c][s] = (s == 2); m_fid[c][s] = (s == 2) ? 'h004 : 0;
        m_fpg[c][s] = 0; m_fus[c][s] = 0; m_bid[c][s] = 0; m_cnt[c][s] = 0;
      end
      m_dpg[c] = 0; m_dus[c] = 0; e_ov[c] = 0;
    end
    e_err = 0;
  endtask

  function automatic bit cfg_legal();
    return (c_slot >= 2) && !(c_fx && c_slot == 7);
  endfunction

  task automatic model_eval();
    for (int c = 0; c < 2; c++) begin
      bit found = 0;
      e_rdy[c] = 0; ev_fix[c] = 0; ev_sel[c] = 0;
      for (int s = 2; s < 8; s++)
        if (!found && m_fix[c][s] != 0 && m_fid[c][s] == int'(b_qid[c])) begin
          found = 1; ev_sel[c] = s; ev_fix[c] = 1; e_rdy[c] = 1;
        end
      for (int s = 2; s < 8; s++)
        if (!found && m_fix[c][s] == 0 && m_cnt[c][s] > 0 && m_bid[c][s] == int'(b_qid[c])) begin
          found = 1; ev_sel[c] = s; e_rdy[c] = (m_cnt[c][s] < 7);
        end
      for (int s = 2; s < 8; s++)
        if (!found && m_fix[c][s] == 0 && m_cnt[c][s] == 0) begin
          found = 1; ev_sel[c] = s; e_rdy[c] = 1;
        end
      ev_acc[c] = b_qv[c] && e_rdy[c];
    end
  endtask

  task automatic model_commit();
    for (int c = 0; c < 2; c++) begin
      e_ov[c] = ev_acc[c];
      if (ev_acc[c]) begin
        int s = ev_sel[c];
        int pg = ev_fix[c] ? m_fpg[c][s] : m_dpg[c];
        int us = ev_fix[c] ? m_fus[c][s] : m_dus[c];
        if (b_qid[c][11] == 1'b0 && b_qid[c][2:0] == 3'b000) us = int'(b_quser[c]);
        e_oid[c] = s;
        e_oaddr[c] = {pg[1:0], b_qaddr[c][29:0]};
        e_ouser[c] = us;
      end
      for (int s = 2; s < 8; s++) begin
        bit inc = ev_acc[c] && !ev_fix[c] && ev_sel[c] == s;
        bit dec = b_dv[c] && int'(b_did[c]) == s && m_fix[c][s] == 0 && m_cnt[c][s] > 0;
        if (c_we && !c_dyn && int'(c_chan) == c && cfg_legal() && int'(c_slot) == s) begin
          m_fix[c][s] = c_fx; m_fid[c][s] = c_id; m_fpg[c][s] = c_pg;
          m_fus[c][s] = c_us; m_cnt[c][s] = 0;
        end else begin
          if (inc) m_bid[c][s] = b_qid[c];
          m_cnt[c][s] = m_cnt[c][s] + inc - dec;
        end
      end
      if (c_we && c_dyn && int'(c_chan) == c) begin
        m_dpg[c] = c_pg; m_dus[c] = c_us;
      end
    end
    e_err = c_we && !c_dyn && !cfg_legal();
  endtask

  task automatic idle();
    b_qv = 0; b_dv = 0; c_we = 0; c_chan = 0; c_dyn = 0; c_fx = 0;
    c_slot = 0; c_id = 0; c_pg = 0; c_us = 0;
    for (int c = 0; c < 2; c++) begin
      b_qid[c] = 0; b_qaddr[c] = 0; b_quser[c] = 0; b_did[c] = 0;
    end
  endtask

  task automatic check_outs();
    for (int c = 0; c < 2; c++) begin
      chk(t_ov[c], e_ov[c], $sformatf("ch%0d out_valid", c));
      if (e_ov[c]) begin
        chk(t_oid[c], e_oid[c], $sformatf("ch%0d out_id", c));
        chk(t_oaddr[c], e_oaddr[c], $sformatf("ch%0d out_addr", c));
        chk(t_ouser[c], e_ouser[c], $sformatf("ch%0d out_user", c));
      end
    end
    chk(t_err, e_err, "cfg_err");
  endtask

  // One clock: inputs are already set; compare ready before the edge, outputs after.
  task automatic tick();
    #1;
    model_eval();
    for (int c = 0; c < 2; c++) chk(t_qr[c], e_rdy[c], $sformatf("ch%0d ready", c));
    @(posedge clk);
    model_commit();
    @(negedge clk);
    check_outs();
    idle();
  endtask

  task automatic req(input int c, input int id, input logic [31:0] a, input int u);
    b_qv[c] = 1; b_qid[c] = id; b_qaddr[c] = a; b_quser[c] = u;
  endtask

  task automatic done(input int c, input int s);
    b_dv[c] = 1; b_did[c] = s;
  endtask

  task automatic cfgw(input int ch, input int dyn, input int slot, input int fx,
                      input int id, input int pg, input int us);
    c_we = 1; c_chan = ch; c_dyn = dyn; c_slot = slot; c_fx = fx;
    c_id = id; c_pg = pg; c_us = us;
  endtask

  initial begin
    idle();
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;

    tag = "R1";
    check_outs();
    tick();
    req(0, 'h004, 32'h1000_0000, 9); req(1, 'h004, 32'h0000_0010, 3); tick();
    chk(t_oid[0], 2, "reset fixed read slot");
    chk(t_oid[1], 2, "reset fixed write slot");
    chk(t_ouser[0], 0, "reset fixed user");

    tag = "R12";
    cfgw(0, 1, 0, 0, 0, 3, 'h0A); tick();
    tag = "R7";
    req(0, 'h011, 32'h0000_1234, 1); tick();
    chk(t_oid[0], 3, "first pooled slot");
    chk(t_oaddr[0], 32'hC000_1234, "paged addr");
    chk(t_ouser[0], 'h0A, "pooled user");

    tag = "R4";
    req(0, 'h011, 32'h4000_0008, 1); tick();
    chk(t_oid[0], 3, "reuse bound slot");

    tag = "R3";
    for (int k = 0; k < 5; k++) begin
      req(1, 'h101 + k, 32'h0000_0100 * k, 2); tick();
      chk(t_oid[1], 3 + k, "lowest free slot order");
    end

    tag = "R6";
    req(1, 'h106, 32'h0, 0); tick();
    chk(t_ov[1], 0, "stall with pool empty");

    tag = "R5";
    done(1, 5); tick();
    req(1, 'h106, 32'h0, 0); tick();
    chk(t_oid[1], 5, "freed slot reused");
    done(1, 2); req(1, 'h107, 32'h0, 0); tick();
    done(1, 7); req(1, 'h105, 32'h8, 0); tick();

    tag = "R6";
    for (int k = 0; k < 5; k++) begin
      req(0, 'h011, 32'h10 * k, 4); tick();
    end
    req(0, 'h011, 32'h0, 4); tick();
    chk(t_ov[0], 0, "counter ceiling stall");
    tag = "R5";
    done(0, 3); req(0, 'h011, 32'h0, 4); tick();
    req(0, 'h011, 32'h0, 4); done(0, 3); tick();

    tag = "R2";
    cfgw(0, 0, 4, 1, 'h123, 2, 'h15); tick();
    req(0, 'h123, 32'h0000_0040, 'h1F); tick();
    chk(t_oid[0], 4, "fixed slot id");
    chk(t_oaddr[0], 32'h8000_0040, "fixed page");
    chk(t_ouser[0], 'h15, "fixed user");
    cfgw(0, 0, 6, 1, 'h011, 1, 7); tick();
    req(0, 'h011, 32'h0, 0); tick();
    chk(t_oid[0], 6, "fixed beats pooled binding");

    tag = "R12";
    cfgw(0, 0, 3, 0, 0, 0, 0); tick();
    req(0, 'h222, 32'h0, 0); tick();
    chk(t_oid[0], 3, "reconfigured slot is free");

    tag = "R8";
    req(0, 'h0F8, 32'h0, 'h1B); tick();
    chk(t_ouser[0], 'h1B, "bridge user passthrough");
    req(0, 'h808, 32'h0, 'h1B); tick();
    chk(t_ouser[0], 'h0A, "other master user replaced");

    tag = "R9";
    req(1, 'h123, 32'h0, 1); req(0, 'h123, 32'h0, 1); tick();
    chk(t_oid[0], 4, "read fixed binding");
    chk(t_ouser[1] == 5'h0A, 0, "write not using read pool user");

    tag = "R10";
    cfgw(0, 0, 1, 1, 'h321, 0, 0); tick();
    chk(t_err, 1, "reserved slot write");
    tick();
    chk(t_err, 0, "error is one pulse");
    cfgw(1, 0, 7, 1, 'h321, 0, 0); tick();
    chk(t_err, 1, "fixed top slot write");
    cfgw(0, 0, 0, 0, 'h321, 0, 0); tick();
    req(0, 'h321, 32'h0, 0); tick();
    chk(t_oid[0] > 1, 1, "refused write had no effect");
    cfgw(1, 0, 7, 0, 0, 0, 0); tick();
    chk(t_err, 0, "pooled top slot write is legal");

    tag = "R11";
    for (int k = 0; k < 400; k++) begin
      int ids[12] = '{'h004, 'h0F8, 'h800, 'h123, 'h011, 'h020, 'h031, 'h040,
                      'h055, 'h066, 'h077, 'h808};
      for (int c = 0; c < 2; c++) begin
        if ($urandom_range(9) < 6) req(c, ids[$urandom_range(11)], $urandom, $urandom_range(31));
        if ($urandom_range(9) < 5) done(c, $urandom_range(7, 2));
      end
      if ($urandom_range(99) < 4)
        cfgw($urandom_range(1), $urandom_range(4) == 0, $urandom_range(7), $urandom_range(1),
             ids[$urandom_range(11)], $urandom_range(3), $urandom_range(31));
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule